// File: doc/BRIEF.md
# Graphics Clock Burst Control Register

This block is the power-unit end of a graphics clock burst interface. A host writes a 32-bit control word through a simple write strobe. The block keeps a latched copy of the top bit of that word and accepts a write only when the new top bit differs from the latched copy. Repeated or stale writes therefore change nothing. An accepted write updates the notification enable, the automatic-burst enable and, for a legal request code, the processed request and the selected clock speed.

A 32-bit status word is always readable. It merges several pieces of state: the fuse that permits bursting, the stored settings, the last processed request, and a 4-bit clock code. The clock code combines the selected speed with a throttle level supplied from outside the block. Whenever that clock code changes while notification is enabled, the block raises a one-cycle interrupt pulse. Bus transport, interrupt routing and the actual clock switching are left to surrounding logic.

Top module: `burst_pwr_ctrl`

## Requirements
- R1: A write with `wrData[31]` equal to the latched toggle bit is ignored: no status bit changes because of it. A write whose bit 31 differs is accepted, and that bit becomes the new latched toggle.
- R2: On an accepted write, control bit 30 (notify enable) appears at status bit 30 and control bit 28 (auto burst enable) appears at status bit 28 from the next cycle onward.
- R3: An accepted request field `wrData[27:24]` of 0000 (exit, 400 MHz) or 0001 (entry, 533 MHz) is copied to status bits 27:24. With the fuse at 1 and throttle 0, entry gives clock code 0001 in status bits 23:20, and exit gives 0000.
- R4: An accepted write with any other request code (0010 to 1111) leaves status bits 27:24 and the clock selection unchanged, while bits 30 and 28 are still taken from the write.
- R5: An entry request accepted while `burstFuse` is 0 sets status bits 27:24 to 0001, but the clock stays at 400 MHz (code 0000 at throttle 0).
- R6: With a nonzero `throttleLvl` t, status bits 23:20 read {1, t} (1001 to 1111, 400 MHz throttled in 12.5% steps) in the same cycle, whatever speed is selected. Code 0001 is reported only when t is 0 and entry is granted.
- R7: Status bit 31 follows `burstFuse` combinationally.
- R8: When status bits 23:20 at one clock edge differ from their value at the previous edge and notify enable was 1, `freqIrq` is high for the following cycle. With notify enable 0 it stays low.
- R9: After reset the latched toggle is 0, all stored fields are 0, and status reads {burstFuse, 31'b0}. Status bits 29 and 19:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word |
| burstFuse | input | 1 | 1 = bursting permitted |
| throttleLvl | input | 3 | Throttle step, 0 = none, 1..7 = 12.5% steps |
| statusWord | output | 32 | Status word |
| freqIrq | output | 1 | Clock-change interrupt pulse |

## Verification
A write sampled at a rising edge shows in the status word right after that edge. A change of fuse or throttle shows in the same cycle, because the status encoding is combinational. The interrupt follows one edge later than the code change it reports, and lasts one cycle. The bench drives inputs on falling edges and compares every output against a behavioural model a quarter period after each rising edge. Directed checks wait exactly those edge counts before sampling.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int WORD_W  = 32;
  localparam int CODE_W  = 4;
  localparam int THR_W   = 3;
  // field positions the host and the status reader depend on
  localparam int TOG_BIT  = 31;
  localparam int IE_BIT   = 30;
  localparam int AUTO_BIT = 28;
  localparam int REQ_LSB  = 24;
  localparam int LOW_PAD  = REQ_LSB - CODE_W;   // 20 reserved low bits
  localparam logic [CODE_W-1:0] REQ_EXIT  = 4'b0000;
  localparam logic [CODE_W-1:0] REQ_ENTER = 4'b0001;

  typedef struct packed {
    logic accept;   // genuine new write
    logic loadReq;  // request code is legal
    logic setFast;  // grant 533 MHz
  } ctrlStrobe_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic              wrEn,
  input  logic              toggleIn,
  input  logic [CODE_W-1:0] reqIn,
  input  logic              toggleQ,
  input  logic              burstFuse,
  output ctrlStrobe_t       strb
);
  logic reqLegal;

  always_comb begin
    reqLegal     = (reqIn == REQ_EXIT) || (reqIn == REQ_ENTER);
    strb.accept  = wrEn && (toggleIn != toggleQ);
    strb.loadReq = strb.accept && reqLegal;
    strb.setFast = strb.loadReq && (reqIn == REQ_ENTER) && burstFuse;
  end
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              burstFuse,
  input  logic [THR_W-1:0]  throttleLvl,
  input  ctrlStrobe_t       strb,
  output logic              toggleQ,
  output logic [WORD_W-1:0] statusWord,
  output logic              freqIrq
);
  logic              irqEnQ, autoQ, fastQ;
  logic [CODE_W-1:0] reqQ, codeHist, curCode;

  always_comb begin
    if (throttleLvl != '0) curCode = {1'b1, throttleLvl};
    else                   curCode = {{(CODE_W-1){1'b0}}, fastQ};
    statusWord = {burstFuse, irqEnQ, 1'b0, autoQ, reqQ, curCode, {LOW_PAD{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleQ  <= 1'b0;
      irqEnQ   <= 1'b0;
      autoQ    <= 1'b0;
      fastQ    <= 1'b0;
      reqQ     <= '0;
      codeHist <= '0;
      freqIrq  <= 1'b0;
    end else begin
      codeHist <= curCode;
      freqIrq  <= irqEnQ && (curCode != codeHist);
      if (strb.accept) begin
        toggleQ <= wrData[TOG_BIT];
        irqEnQ  <= wrData[IE_BIT];
        autoQ   <= wrData[AUTO_BIT];
      end
      if (strb.loadReq) begin
        reqQ  <= wrData[REQ_LSB +: CODE_W];
        fastQ <= strb.setFast;
      end
    end
  end

  // R1
  stale_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[TOG_BIT] == toggleQ) |=> $stable({toggleQ, irqEnQ, autoQ, reqQ, fastQ}));
  // R2
  enable_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (statusWord[IE_BIT] == $past(wrData[IE_BIT])));
  // R4
  rsvd_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && !strb.loadReq) |=> $stable({reqQ, fastQ}));
  // R5
  no_fuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadReq && !burstFuse) |=> !fastQ);
  // R6
  throttle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (throttleLvl != '0) |-> (statusWord[REQ_LSB-1] && statusWord[REQ_LSB-CODE_W +: THR_W] == throttleLvl));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    freqIrq |-> $past(irqEnQ));
endmodule

// File: rtl/burst_pwr_ctrl.sv
module burst_pwr_ctrl
  import burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        burstFuse,
  input  logic [2:0]  throttleLvl,
  output logic [31:0] statusWord,
  output logic        freqIrq
);
  ctrlStrobe_t strb;
  logic        toggleQ;

  burst_ctrl uCtrl (
    .wrEn      (wrEn),
    .toggleIn  (wrData[TOG_BIT]),
    .reqIn     (wrData[REQ_LSB +: CODE_W]),
    .toggleQ   (toggleQ),
    .burstFuse (burstFuse),
    .strb      (strb)
  );

  burst_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .burstFuse   (burstFuse),
    .throttleLvl (throttleLvl),
    .strb        (strb),
    .toggleQ     (toggleQ),
    .statusWord  (statusWord),
    .freqIrq     (freqIrq)
  );
endmodule

// File: tb/sim_burst_pwr_ctrl.sv
module sim_burst_pwr_ctrl;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        burstFuse = 1'b1;
  logic [2:0]  throttleLvl = '0;
  wire  [31:0] statusWord;
  wire         freqIrq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit       mTog, mIe, mAuto, mFast, mIrq;
  bit [3:0] mReq, mPrev;

  burst_pwr_ctrl u0 (.*);

  always #(CLK_PER/2) clk = ~clk;

  function automatic [3:0] modelCode(bit fast, bit [2:0] t);
    if (t != 0) return 4'd8 + 4'(t);
    return fast ? 4'd1 : 4'd0;
  endfunction

  function automatic [31:0] modelStatus();
    return {burstFuse, mIe, 1'b0, mAuto, mReq, modelCode(mFast, throttleLvl), 20'h0};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTog = 0; mIe = 0; mAuto = 0; mFast = 0; mIrq = 0; mReq = 0; mPrev = 0;
    end else begin
      mIrq  = mIe && (modelCode(mFast, throttleLvl) != mPrev);
      mPrev = modelCode(mFast, throttleLvl);
      if (wrEn && wrData[31] != mTog) begin
        mTog = wrData[31]; mIe = wrData[30]; mAuto = wrData[28];
        if (wrData[27:24] == 4'd0) begin mReq = 0; mFast = 0; end
        else if (wrData[27:24] == 4'd1) begin mReq = 1; mFast = burstFuse; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rstN && !done) begin
      chk("R3/R6/R7 per-cycle status", statusWord, modelStatus());
      chk("R8 per-cycle irq", {31'b0, freqIrq}, {31'b0, mIrq});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic [31:0] word(bit tog, bit ie, bit auto, bit [3:0] req);
    return {tog, ie, 1'b0, auto, req, 24'h0};
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk); wrEn = 1'b1; wrData = w;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic irqAfter(input string tag, input bit exp);
    @(posedge clk); #(CLK_PER/4);
    chk(tag, {31'b0, freqIrq}, {31'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset status", statusWord, 32'h8000_0000);
    chk("R9 reset irq", {31'b0, freqIrq}, 32'h0);

    // toggle latched 0 after reset: a write with bit31=0 is stale
    wr(word(0, 1, 1, 4'd1));
    chk("R1 stale write ignored", statusWord, 32'h8000_0000);

    // genuine entry write
    wr(word(1, 1, 1, 4'd1));
    chk("R2 R3 entry status", statusWord, 32'hD110_0000);
    irqAfter("R8 irq pulse on entry", 1'b1);
    irqAfter("R8 irq single cycle", 1'b0);

    // same toggle again with exit: ignored
    wr(word(1, 1, 1, 4'd0));
    chk("R1 repeat toggle ignored", statusWord, 32'hD110_0000);

    // reserved request code: fields 27:24 and clock kept, auto bit cleared
    wr(word(0, 1, 0, 4'd5));
    chk("R4 reserved request", statusWord, 32'hC110_0000);
    irqAfter("R4 no irq on reserved", 1'b0);

    // throttle overrides 533 MHz
    @(negedge clk); throttleLvl = 3'd3; #1;
    chk("R6 throttle 3", statusWord, 32'hC1B0_0000);
    irqAfter("R8 irq on throttle", 1'b1);
    @(negedge clk); throttleLvl = 3'd7; #1;
    chk("R6 throttle 7", statusWord, 32'hC1F0_0000);
    @(negedge clk); throttleLvl = 3'd0; #1;
    chk("R6 back to 533", statusWord, 32'hC110_0000);
    repeat (3) @(negedge clk);

    // exit, then fuse 0 entry
    wr(word(1, 1, 0, 4'd0));
    chk("R3 exit status", statusWord, 32'hC000_0000);
    repeat (3) @(negedge clk);
    burstFuse = 1'b0; #1;
    chk("R7 fuse low", statusWord, 32'h4000_0000);
    wr(word(0, 1, 0, 4'd1));
    chk("R5 entry without fuse", statusWord, 32'h4100_0000);
    irqAfter("R5 no irq, clock unchanged", 1'b0);

    // notify disabled: throttle change gives no interrupt
    burstFuse = 1'b1;
    wr(word(1, 0, 1, 4'd1));
    chk("R2 ie cleared, auto set", statusWord, 32'h9110_0000);
    repeat (2) @(negedge clk);
    throttleLvl = 3'd1; #1;
    chk("R6 throttle 1", statusWord, 32'h9190_0000);
    irqAfter("R8 no irq when disabled", 1'b0);
    irqAfter("R8 no irq when disabled 2", 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule